// File: doc/BRIEF.md
# Memory Card SPI Start-Up Sequencer

This block takes a memory card in SPI mode from power-up to a usable state. It sends the wake-up clocks, resets the card into idle and asks it to confirm its supply voltage. From the replies it learns the card generation, then polls the card until it leaves idle. On capacity-capable cards it reads the operating-condition register, and it finally fixes the block length at 512 bytes. The bus clock stays at identification speed for the whole sequence. It is raised only when the card is ready.

The block does not shift bits itself. It hands one operation at a time to a command framer through a request/done port. An operation is one of three kinds: a full command frame with its one-byte reply, a single received byte with chip select low, or an idle byte with chip select high. The framer adds the start bits and the CRC. A card-detect input gates the whole run. When the run ends, the block shows either ready or error, the card type flags and whether data addresses are block numbers.

Top module: `sdspi_boot`

## Requirements
- R1: After `start` with the card present, exactly `WAKE_BYTES` operations of kind 2 (idle byte, chip select high) are issued before any other operation. The first command (kind 0) is command 0.
- R2: Command 0 is repeated until its reply equals 8'h01. If `IDLE_TRIES` replies in a row differ from 8'h01, the run ends in error.
- R3: Command 8 is sent with argument 32'h000001AA. If reply bit 2 (illegal command) is clear, four bytes are read (kind 1). The third byte must have bit 0 set and the fourth must equal 8'hAA, otherwise the run ends in error. On success `card_type[1]` (version 2) is set.
- R4: If the command 8 reply has bit 2 set, command 55 and then command 41 with argument 0 are sent. If that reply has bit 2 clear, `card_type[0]` (version 1) is set. Otherwise the card is treated as MMC, with `card_type` = 3'b000.
- R5: The ready loop repeats until a reply has bit 0 (idle) clear. For SD cards each try is command 55 followed by command 41, with argument 32'h40000000 for version 2 and 0 for version 1. For MMC each try is command 1 with argument 0.
- R6: After `READY_TRIES` ready-loop replies that are all still idle, the run ends in error and `spi_fast` stays 0.
- R7: For version 2 cards, command 58 is sent. A nonzero reply is an error. Otherwise four bytes are read, and bit 6 of the first one sets `card_type[2]` (high capacity) and `blk_addr`.
- R8: Command 16 is sent with argument 512. A nonzero reply ends the run in error, otherwise in ready.
- R9: `spi_fast` is 0 from reset and through the whole run. It is 1 exactly while `ready` is 1.
- R10: If `card_present` is low at `start`, or drops while `busy`, `error` is set on the next cycle and no further operation is requested.
- R11: While `op_req` is high and `op_done` has not arrived, `op_kind`, `op_cmd` and `op_arg` hold their values.
- R12: `ready` and `error` are never high together. A new `start` after either of them clears the type flags and `spi_fast` and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence when not busy |
| card_present | input | 1 | High while a card sits in the slot |
| op_req | output | 1 | An operation is requested from the framer |
| op_kind | output | 2 | 0 command + reply, 1 receive byte, 2 idle byte with CS high |
| op_cmd | output | 6 | Command index for kind 0 |
| op_arg | output | 32 | Command argument for kind 0 |
| op_done | input | 1 | One-cycle pulse: current operation finished |
| op_data | input | 8 | Reply or received byte, valid with op_done |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Sequence finished successfully |
| error | output | 1 | Sequence failed |
| card_type | output | 3 | {high capacity, version 2, version 1}; zero for MMC |
| blk_addr | output | 1 | Data addresses are block numbers |
| spi_fast | output | 1 | Select the fast bus clock |

## Verification
The assertions assume that the framer pulses `op_done` for one cycle, and only while `op_req` is high. They also assume that `start` is not pulsed while a run is busy. The bench's framer model keeps to this. It completes an operation only after seeing `op_req` held for a few cycles, and it drops its partial count when the request goes away. `start` is applied only between runs. Card removal is the single disturbance injected during a run, and the stability property on the request excludes the cycles with no card present.

// File: rtl/sdspi_boot.sv
module sdspi_boot #(
  parameter int WAKE_BYTES  = 10,
  parameter int IDLE_TRIES  = 512,
  parameter int READY_TRIES = 32'h7FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        card_present,
  output logic        op_req,
  output logic [1:0]  op_kind,
  output logic [5:0]  op_cmd,
  output logic [31:0] op_arg,
  input  logic        op_done,
  input  logic [7:0]  op_data,
  output logic        busy,
  output logic        ready,
  output logic        error,
  output logic [2:0]  card_type,
  output logic        blk_addr,
  output logic        spi_fast
);
  localparam int MAXA = (READY_TRIES > IDLE_TRIES) ? READY_TRIES : IDLE_TRIES;
  localparam int MAXT = (MAXA > WAKE_BYTES) ? MAXA : WAKE_BYTES;
  localparam int CW   = $clog2(MAXT + 1) + 1;

  localparam logic [1:0] K_CMD = 2'd0, K_BYTE = 2'd1, K_IDLE = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_WAKE, S_GO, S_IFC, S_IFB, S_PAPP, S_PRB,
    S_RAPP, S_ROP, S_OCRC, S_OCRB, S_BLEN, S_DONE, S_FAIL
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          v1, v2, hc;

  assign busy      = !(state inside {S_IDLE, S_DONE, S_FAIL});
  assign ready     = (state == S_DONE);
  assign error     = (state == S_FAIL);
  assign card_type = {hc, v2, v1};
  assign blk_addr  = hc;
  assign op_req    = busy && card_present;

  always_comb begin
    op_kind = K_CMD;
    op_cmd  = 6'd0;
    op_arg  = 32'd0;
    case (state)
      S_WAKE: op_kind = K_IDLE;
      S_IFC:  begin op_cmd = 6'd8;  op_arg = 32'h0000_01AA; end
      S_IFB, S_OCRB: op_kind = K_BYTE;
      S_PAPP, S_RAPP: op_cmd = 6'd55;
      S_PRB:  op_cmd = 6'd41;
      S_ROP:  begin
        op_cmd = (v1 || v2) ? 6'd41 : 6'd1;
        op_arg = v2 ? 32'h4000_0000 : 32'd0;
      end
      S_OCRC: op_cmd = 6'd58;
      S_BLEN: begin op_cmd = 6'd16; op_arg = 32'd512; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      v1       <= 1'b0;
      v2       <= 1'b0;
      hc       <= 1'b0;
      spi_fast <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        v1       <= 1'b0;
        v2       <= 1'b0;
        hc       <= 1'b0;
        spi_fast <= 1'b0;
        cnt      <= '0;
        state    <= card_present ? S_WAKE : S_FAIL;
      end
    end else if (!card_present) begin
      state <= S_FAIL;
    end else if (op_done) begin
      case (state)
        S_WAKE: begin
          if (cnt == CW'(WAKE_BYTES - 1)) begin cnt <= '0; state <= S_GO; end
          else cnt <= cnt + 1'b1;
        end
        S_GO: begin
          if (op_data == 8'h01) begin cnt <= '0; state <= S_IFC; end
          else if (cnt == CW'(IDLE_TRIES - 1)) state <= S_FAIL;
          else cnt <= cnt + 1'b1;
        end
        S_IFC: begin
          cnt   <= '0;
          state <= op_data[2] ? S_PAPP : S_IFB;
        end
        S_IFB: begin
          if (cnt == CW'(2) && !op_data[0]) state <= S_FAIL;
          else if (cnt == CW'(3)) begin
            if (op_data != 8'hAA) state <= S_FAIL;
            else begin v2 <= 1'b1; cnt <= '0; state <= S_RAPP; end
          end else cnt <= cnt + 1'b1;
        end
        S_PAPP: state <= S_PRB;
        S_PRB: begin
          cnt <= '0;
          if (!op_data[2]) begin v1 <= 1'b1; state <= S_RAPP; end
          else state <= S_ROP;
        end
        S_RAPP: state <= S_ROP;
        S_ROP: begin
          if (!op_data[0]) begin cnt <= '0; state <= v2 ? S_OCRC : S_BLEN; end
          else if (cnt == CW'(READY_TRIES - 1)) state <= S_FAIL;
          else begin cnt <= cnt + 1'b1; state <= (v1 || v2) ? S_RAPP : S_ROP; end
        end
        S_OCRC: begin
          cnt   <= '0;
          state <= (op_data != 8'h00) ? S_FAIL : S_OCRB;
        end
        S_OCRB: begin
          if (cnt == CW'(0)) hc <= op_data[6];
          if (cnt == CW'(3)) state <= S_BLEN;
          else cnt <= cnt + 1'b1;
        end
        S_BLEN: begin
          if (op_data != 8'h00) state <= S_FAIL;
          else begin spi_fast <= 1'b1; state <= S_DONE; end
        end
        default: state <= S_FAIL;
      endcase
    end
  end

  p_absent_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !card_present |=> error && !op_req);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_req && !op_done |=> !card_present ||
      (op_req && $stable(op_kind) && $stable(op_cmd) && $stable(op_arg)));

  p_fast_only_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_fast == ready);

  p_outcome_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && error));

  p_hc_needs_v2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    card_type[2] |-> card_type[1]);

  p_gen_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_type[0] && card_type[1]));

  p_ready_arg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_req && op_kind == 2'd0 && op_cmd == 6'd41 && card_type[1]
      |-> op_arg == 32'h4000_0000);
endmodule

// File: tb/sdspi_boot_tb.sv
module sdspi_boot_tb;
  localparam int WB = 10, IT = 8, RT = 20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, card_present = 1'b1;
  logic op_req, op_done = 1'b0, busy, ready, error, blk_addr, spi_fast;
  logic [1:0] op_kind;
  logic [5:0] op_cmd;
  logic [31:0] op_arg;
  logic [7:0] op_data = 8'h00;
  logic [2:0] card_type;

  always #10 clk = ~clk;

  sdspi_boot #(.WAKE_BYTES(WB), .IDLE_TRIES(IT), .READY_TRIES(RT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .card_present(card_present),
    .op_req(op_req), .op_kind(op_kind), .op_cmd(op_cmd), .op_arg(op_arg),
    .op_done(op_done), .op_data(op_data), .busy(busy), .ready(ready),
    .error(error), .card_type(card_type), .blk_addr(blk_addr), .spi_fast(spi_fast));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit ended = 0;

  int sc_cmd0_bad, sc_busy;
  bit sc_if_ill, sc_prb_ill;
  logic [7:0] sc_r7b2, sc_r7b3, sc_ocr_r1, sc_ocr0, sc_blen_r1;

  int n_cmd [64];
  logic [31:0] last_arg [64];
  int n_idle_before, n_ops, n_rdy, byte_idx, last_cmd, first_cmd, lat;
  bit seen_cmd;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_scenario(input int c0bad, input bit ifill, input logic [7:0] b2,
                              input logic [7:0] b3, input bit prbill, input int bsy,
                              input logic [7:0] ocrr, input logic [7:0] ocr0, input logic [7:0] blr);
    sc_cmd0_bad = c0bad; sc_if_ill = ifill; sc_r7b2 = b2; sc_r7b3 = b3;
    sc_prb_ill = prbill; sc_busy = bsy; sc_ocr_r1 = ocrr; sc_ocr0 = ocr0; sc_blen_r1 = blr;
    for (int i = 0; i < 64; i++) begin n_cmd[i] = 0; last_arg[i] = 32'hDEAD_BEEF; end
    n_idle_before = 0; n_ops = 0; n_rdy = 0; byte_idx = 0; last_cmd = -1;
    first_cmd = -1; seen_cmd = 0;
  endtask

  function automatic logic [7:0] reply(input logic [1:0] k, input int c);
    if (k == 2'd2) return 8'hFF;
    if (k == 2'd1) begin
      if (last_cmd == 8) return (byte_idx == 2) ? sc_r7b2 : (byte_idx == 3) ? sc_r7b3 : 8'h00;
      if (last_cmd == 58) return (byte_idx == 0) ? sc_ocr0 : 8'hFF;
      return 8'hFF;
    end
    case (c)
      0:  return (n_cmd[0] < sc_cmd0_bad) ? 8'h00 : 8'h01;
      8:  return sc_if_ill ? 8'h05 : 8'h01;
      55: return 8'h01;
      41: if (sc_if_ill && n_cmd[41] == 0) return sc_prb_ill ? 8'h05 : 8'h01;
          else return (n_rdy < sc_busy) ? 8'h01 : 8'h00;
      1:  return (n_rdy < sc_busy) ? 8'h01 : 8'h00;
      58: return sc_ocr_r1;
      16: return sc_blen_r1;
      default: return 8'h04;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      op_done <= 1'b0; lat = 0;
    end else if (op_done) begin
      op_done <= 1'b0;
    end else if (op_req) begin
      if (lat == 2) begin
        lat = 0;
        op_done <= 1'b1;
        op_data <= reply(op_kind, int'(op_cmd));
        n_ops++;
        if (op_kind == 2'd2 && !seen_cmd) n_idle_before++;
        if (op_kind == 2'd1) byte_idx++;
        if (op_kind == 2'd0) begin
          if (!seen_cmd) first_cmd = int'(op_cmd);
          seen_cmd = 1;
          if (int'(op_cmd) == 1 || (int'(op_cmd) == 41 && !(sc_if_ill && n_cmd[41] == 0))) n_rdy++;
          n_cmd[op_cmd]++;
          last_arg[op_cmd] = op_arg;
          last_cmd = int'(op_cmd);
          byte_idx = 0;
        end
      end else lat++;
    end else lat = 0;
  end

  task automatic run(input bit present);
    @(negedge clk);
    card_present = present;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000 && !(ready || error); i++) @(negedge clk);
  endtask

  task automatic expect_end(input bit ok, input logic [2:0] ty, input string tag);
    check(ready == ok, tag, ready, ok);
    check(error == !ok, tag, error, !ok);
    check(spi_fast == ok, {tag, "/R9"}, spi_fast, ok);
    if (ok) check(card_type == ty, tag, card_type, ty);
  endtask

  task automatic t_reset;
    check(!busy && !ready && !error && !spi_fast && !op_req, "R9 reset", {busy, ready, error, spi_fast, op_req}, 0);
  endtask

  task automatic t_v2hc;
    set_scenario(2, 0, 8'h01, 8'hAA, 0, 3, 8'h00, 8'hC0, 8'h00);
    run(1);
    expect_end(1, 3'b110, "R7 v2 high capacity");
    check(n_idle_before == WB, "R1 wake bytes", n_idle_before, WB);
    check(first_cmd == 0, "R1 first command", first_cmd, 0);
    check(n_cmd[0] == 3, "R2 cmd0 retries", n_cmd[0], 3);
    check(last_arg[8] == 32'h1AA, "R3 cmd8 arg", last_arg[8], 32'h1AA);
    check(n_cmd[41] == 4 && n_cmd[55] == 4, "R5 v2 ready tries", n_cmd[41], 4);
    check(last_arg[41] == 32'h4000_0000, "R5 v2 ready arg", last_arg[41], 32'h4000_0000);
    check(blk_addr == 1, "R7 blk_addr", blk_addr, 1);
    check(last_arg[16] == 512 && n_cmd[16] == 1, "R8 blocklen arg", last_arg[16], 512);
  endtask

  task automatic t_v2sc;
    set_scenario(0, 0, 8'h01, 8'hAA, 0, 0, 8'h00, 8'h80, 8'h00);
    run(1);
    expect_end(1, 3'b010, "R7 v2 standard capacity");
    check(blk_addr == 0 && n_cmd[58] == 1, "R7 blk_addr clear", blk_addr, 0);
  endtask

  task automatic t_v1;
    set_scenario(0, 1, 8'h00, 8'h00, 0, 2, 8'h00, 8'hFF, 8'h00);
    run(1);
    expect_end(1, 3'b001, "R4 v1 card");
    check(n_cmd[41] == 4 && last_arg[41] == 0, "R5 v1 ready arg", last_arg[41], 0);
    check(n_cmd[58] == 0 && n_cmd[1] == 0, "R7 no cmd58 on v1", n_cmd[58], 0);
  endtask

  task automatic t_mmc;
    set_scenario(0, 1, 8'h00, 8'h00, 1, 5, 8'h00, 8'hFF, 8'h00);
    run(1);
    expect_end(1, 3'b000, "R12 mmc after v2hc, type cleared");
    check(n_cmd[1] == 6 && n_cmd[55] == 1, "R4 mmc uses cmd1", n_cmd[1], 6);
  endtask

  task automatic t_cmd0;
    set_scenario(IT - 1, 0, 8'h01, 8'hAA, 0, 0, 8'h00, 8'h00, 8'h00);
    run(1);
    expect_end(1, 3'b010, "R2 cmd0 last try");
    set_scenario(1000, 0, 8'h01, 8'hAA, 0, 0, 8'h00, 8'h00, 8'h00);
    run(1);
    expect_end(0, 3'b000, "R2 cmd0 exhausted");
    check(n_cmd[0] == IT && n_cmd[8] == 0, "R2 cmd0 count", n_cmd[0], IT);
  endtask

  task automatic t_r7bad;
    set_scenario(0, 0, 8'h00, 8'hAA, 0, 0, 8'h00, 8'h00, 8'h00);
    run(1);
    expect_end(0, 3'b000, "R3 voltage bit clear");
    set_scenario(0, 0, 8'h01, 8'h55, 0, 0, 8'h00, 8'h00, 8'h00);
    run(1);
    expect_end(0, 3'b000, "R3 bad pattern");
    check(n_cmd[55] == 0, "R3 no further commands", n_cmd[55], 0);
  endtask

  task automatic t_ready;
    set_scenario(0, 1, 8'h00, 8'h00, 0, RT - 1, 8'h00, 8'h00, 8'h00);
    run(1);
    expect_end(1, 3'b001, "R6 last ready try");
    set_scenario(0, 1, 8'h00, 8'h00, 0, 1000, 8'h00, 8'h00, 8'h00);
    run(1);
    expect_end(0, 3'b000, "R6 ready exhausted");
    check(n_rdy == RT && n_cmd[16] == 0, "R6 ready count", n_rdy, RT);
  endtask

  task automatic t_tail_errors;
    set_scenario(0, 0, 8'h01, 8'hAA, 0, 0, 8'h01, 8'hC0, 8'h00);
    run(1);
    expect_end(0, 3'b000, "R7 cmd58 nonzero");
    set_scenario(0, 1, 8'h00, 8'h00, 1, 0, 8'h00, 8'h00, 8'h04);
    run(1);
    expect_end(0, 3'b000, "R8 blocklen nonzero");
  endtask

  task automatic t_absent;
    int snap;
    set_scenario(0, 0, 8'h01, 8'hAA, 0, 0, 8'h00, 8'h00, 8'h00);
    run(0);
    check(error && n_ops == 0, "R10 absent at start", n_ops, 0);
    card_present = 1'b1;
    set_scenario(0, 0, 8'h01, 8'hAA, 0, 50, 8'h00, 8'h00, 8'h00);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    for (int i = 0; i < 2000 && n_ops < 15; i++) @(negedge clk);
    card_present = 1'b0;
    @(negedge clk);
    check(error && !op_req, "R10 removal aborts", error, 1);
    snap = n_ops;
    repeat (20) @(negedge clk);
    check(n_ops == snap && !spi_fast, "R10 no ops after abort", n_ops, snap);
    card_present = 1'b1;
  endtask

  always @(negedge clk) begin
    if (cyc > 150000 && !ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    set_scenario(0, 0, 8'h01, 8'hAA, 0, 0, 8'h00, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_v2hc();
    t_mmc();
    t_v2sc();
    t_v1();
    t_cmd0();
    t_r7bad();
    t_ready();
    t_tail_errors();
    t_absent();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule